// File: doc/BRIEF.md
# Load-Locked / Store-Conditional Reservation Monitor

This block keeps the single atomic-update reservation of one processor. A load-locked request records the aligned block that holds its address, the access size (32-bit or 64-bit), and sets a lock flag. The block is 2^BLK_LOG2 bytes. A later store-conditional request writes memory only if the lock is still held, the store falls in the reserved block and its size matches the locked load. The pass/fail outcome comes back as a result word that the core writes into the store's source register. A value of 1 means the write took place. A value of 0 means memory was left untouched and software retries the sequence.

Writes by other agents are watched on a snoop port. Any such write that lands in the reserved block drops the lock. Every store-conditional also drops the lock, whether it passes or fails. So each successful store needs a fresh locked load. All outcomes are registered and appear one cycle after the request.

Top module: `llsc_monitor`

## Requirements
- R1: After reset the lock is clear, so `mem_we` and `sc_done` are 0, and a store-conditional issued with no locked load before it fails.
- R2: A locked load, then a store-conditional of the same size to the same address, gives `mem_we`=1 with `mem_addr`, `mem_data` and `mem_quad` equal to the store's address, data and size, and `sc_result`=1.
- R3: A store-conditional while the lock is clear gives `sc_result`=0 and `mem_we`=0.
- R4: Every store-conditional clears the lock, whether it passes or fails, so a second store-conditional with no new locked load fails.
- R5: A snoop write whose address has the same upper bits `[ADDR_W-1:BLK_LOG2]` as the reservation clears the lock. A snoop write outside that block leaves the lock unchanged.
- R6: A store-conditional whose block differs from the reserved block fails and does not write memory.
- R7: A store-conditional whose size bit (1 = 64-bit, 0 = 32-bit) differs from the size of the locked load fails.
- R8: Address bits `[BLK_LOG2-1:0]` play no part in the block match. A store-conditional at another offset inside the reserved block passes.
- R9: A snoop write into the reserved block in the same cycle as a store-conditional makes that store fail.
- R10: A newer locked load replaces the reservation. Only the newest block can pass.
- R11: `sc_done` is high in exactly the cycle after each store-conditional request. `mem_we` is high only in a cycle where `sc_done` is high and `sc_result` is 1. `sc_result[DATA_W-1:1]` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ll_req | input | 1 | Locked-load strobe |
| ll_quad | input | 1 | Locked-load size: 1 = 64-bit, 0 = 32-bit |
| ll_addr | input | ADDR_W | Locked-load byte address |
| sc_req | input | 1 | Store-conditional strobe |
| sc_quad | input | 1 | Store-conditional size: 1 = 64-bit, 0 = 32-bit |
| sc_addr | input | ADDR_W | Store-conditional byte address |
| sc_data | input | DATA_W | Store-conditional write data |
| snp_wr | input | 1 | Write by another agent seen on the snoop port |
| snp_addr | input | ADDR_W | Snooped write address |
| mem_we | output | 1 | Memory write enable (one cycle) |
| mem_addr | output | ADDR_W | Memory write address |
| mem_data | output | DATA_W | Memory write data |
| mem_quad | output | 1 | Memory write size |
| sc_done | output | 1 | Store-conditional result valid |
| sc_result | output | DATA_W | Result word: 1 = stored, 0 = failed |

## Verification
A locked load or snoop write changes the lock at the next rising edge, so its effect shows up only through a later store-conditional. The outcome of a store-conditional, in `sc_done`, `sc_result` and the memory write outputs, is registered and is due exactly one edge after the request. The bench drives every strobe at a falling edge. It samples the results at the next falling edge, which lies between the capturing edge and the one after it. One more falling edge later it confirms that `sc_done` and `mem_we` have dropped again.

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 64,
  parameter int BLK_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ll_req,
  input  logic              ll_quad,
  input  logic [ADDR_W-1:0] ll_addr,
  input  logic              sc_req,
  input  logic              sc_quad,
  input  logic [ADDR_W-1:0] sc_addr,
  input  logic [DATA_W-1:0] sc_data,
  input  logic              snp_wr,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              mem_quad,
  output logic              sc_done,
  output logic [DATA_W-1:0] sc_result
);

  localparam int TAG_W = ADDR_W - BLK_LOG2;

  logic             lock_q, rsv_quad_q, done_q, ok_q;
  logic [TAG_W-1:0] rsv_tag_q;
  logic [ADDR_W-1:0] waddr_q;
  logic [DATA_W-1:0] wdata_q;
  logic             wquad_q;

  wire [TAG_W-1:0] ll_tag  = ll_addr[ADDR_W-1:BLK_LOG2];
  wire [TAG_W-1:0] sc_tag  = sc_addr[ADDR_W-1:BLK_LOG2];
  wire [TAG_W-1:0] snp_tag = snp_addr[ADDR_W-1:BLK_LOG2];

  wire snp_hit_old = snp_wr && (snp_tag == rsv_tag_q);
  wire snp_hit_new = snp_wr && (snp_tag == ll_tag);
  wire sc_pass     = lock_q && !snp_hit_old && (sc_tag == rsv_tag_q) && (sc_quad == rsv_quad_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q     <= 1'b0;
      rsv_quad_q <= 1'b0;
      rsv_tag_q  <= '0;
    end else if (ll_req) begin
      lock_q     <= !snp_hit_new;
      rsv_quad_q <= ll_quad;
      rsv_tag_q  <= ll_tag;
    end else if (sc_req || snp_hit_old) begin
      lock_q     <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      ok_q    <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
      wquad_q <= 1'b0;
    end else begin
      done_q <= sc_req;
      ok_q   <= sc_req && sc_pass;
      if (sc_req) begin
        waddr_q <= sc_addr;
        wdata_q <= sc_data;
        wquad_q <= sc_quad;
      end
    end
  end

  assign mem_we    = done_q && ok_q;
  assign mem_addr  = waddr_q;
  assign mem_data  = wdata_q;
  assign mem_quad  = wquad_q;
  assign sc_done   = done_q;
  assign sc_result = {{(DATA_W-1){1'b0}}, ok_q};

  a_r11_done_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    sc_req |=> sc_done);
  a_r11_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !sc_req |=> !sc_done);
  a_r11_we_only_on_pass: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (sc_done && sc_result[0]));
  a_r3_no_lock_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_req && !lock_q) |=> !mem_we);
  a_r4_sc_drops_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_req && !ll_req) |=> !lock_q);
  a_r9_snoop_kills_sc: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_req && snp_wr && snp_addr[ADDR_W-1:BLK_LOG2] == rsv_tag_q) |=> !mem_we);
  a_r6_wrong_block_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_req && sc_addr[ADDR_W-1:BLK_LOG2] != rsv_tag_q) |=> !sc_result[0]);

endmodule

// File: tb/sim_llsc_monitor.sv
module sim_llsc_monitor;
  localparam int AW = 32, DW = 64, BL = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ll_req = 0, ll_quad = 0, sc_req = 0, sc_quad = 0, snp_wr = 0;
  logic [AW-1:0] ll_addr = '0, sc_addr = '0, snp_addr = '0;
  logic [DW-1:0] sc_data = '0;
  logic mem_we, mem_quad, sc_done;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data, sc_result;
  int n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  llsc_monitor #(.ADDR_W(AW), .DATA_W(DW), .BLK_LOG2(BL)) u0 (
    .clk(clk), .rst_n(rst_n), .ll_req(ll_req), .ll_quad(ll_quad), .ll_addr(ll_addr),
    .sc_req(sc_req), .sc_quad(sc_quad), .sc_addr(sc_addr), .sc_data(sc_data),
    .snp_wr(snp_wr), .snp_addr(snp_addr), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_quad(mem_quad), .sc_done(sc_done), .sc_result(sc_result));

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_ll(input logic [AW-1:0] a, input logic q);
    @(negedge clk);
    ll_req = 1; ll_addr = a; ll_quad = q;
    @(negedge clk);
    ll_req = 0;
  endtask

  task automatic do_snoop(input logic [AW-1:0] a);
    @(negedge clk);
    snp_wr = 1; snp_addr = a;
    @(negedge clk);
    snp_wr = 0;
  endtask

  task automatic do_sc(input string req, input logic [AW-1:0] a, input logic q,
                       input logic [DW-1:0] d, input logic exp_ok, input logic with_snp);
    @(negedge clk);
    sc_req = 1; sc_addr = a; sc_quad = q; sc_data = d;
    if (with_snp) begin snp_wr = 1; snp_addr = a; end
    @(negedge clk);
    sc_req = 0; snp_wr = 0;
    chk({req, " R11 done"}, DW'(sc_done), 1);
    chk({req, " result"}, sc_result, DW'(exp_ok));
    chk({req, " we"}, DW'(mem_we), DW'(exp_ok));
    if (exp_ok) begin
      chk({req, " R2 addr"}, DW'(mem_addr), DW'(a));
      chk({req, " R2 data"}, mem_data, d);
      chk({req, " R2 size"}, DW'(mem_quad), DW'(q));
    end
    @(negedge clk);
    chk({req, " R11 done drops"}, DW'(sc_done), 0);
    chk({req, " R11 we drops"}, DW'(mem_we), 0);
  endtask

  task automatic t_reset;
    chk("R1 done", DW'(sc_done), 0);
    chk("R1 we", DW'(mem_we), 0);
    do_sc("R1 sc after reset", 32'h100, 1, 64'h11, 0, 0);
  endtask

  task automatic t_basic;
    do_ll(32'h1000, 1);
    do_sc("R2 basic quad", 32'h1000, 1, 64'hDEAD_BEEF_0123_4567, 1, 0);
    do_ll(32'h2040, 0);
    do_sc("R2 basic long", 32'h2040, 0, 64'h0000_0000_CAFE_F00D, 1, 0);
  endtask

  task automatic t_nolock_and_clear;
    do_sc("R3 no lock", 32'h1000, 1, 64'h5, 0, 0);
    do_ll(32'h1000, 1);
    do_sc("R4 first", 32'h1000, 1, 64'h6, 1, 0);
    do_sc("R4 second", 32'h1000, 1, 64'h7, 0, 0);
    do_ll(32'h1000, 1);
    do_sc("R6 outside block", 32'h2000, 1, 64'h8, 0, 0);
    do_sc("R4 after failed sc", 32'h1000, 1, 64'h9, 0, 0);
  endtask

  task automatic t_block_and_size;
    do_ll(32'h3004, 0);
    do_sc("R8 other offset", 32'h300C, 0, 64'hA, 1, 0);
    do_ll(32'h3000, 0);
    do_sc("R7 size mismatch", 32'h3000, 1, 64'hB, 0, 0);
  endtask

  task automatic t_snoop;
    do_ll(32'h4000, 1);
    do_snoop(32'h4008);
    do_sc("R5 snoop inside", 32'h4000, 1, 64'hC, 0, 0);
    do_ll(32'h4000, 1);
    do_snoop(32'h4010);
    do_sc("R5 snoop outside", 32'h4000, 1, 64'hD, 1, 0);
    do_ll(32'h4000, 1);
    do_sc("R9 snoop same cycle", 32'h4000, 1, 64'hE, 0, 1);
  endtask

  task automatic t_relock;
    do_ll(32'h5000, 1);
    do_ll(32'h6000, 1);
    do_sc("R10 old block", 32'h5000, 1, 64'hF, 0, 0);
    do_ll(32'h5000, 1);
    do_ll(32'h6000, 1);
    do_sc("R10 new block", 32'h6000, 1, 64'h10, 1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_basic();
    t_nolock_and_clear();
    t_block_and_size();
    t_snoop();
    t_relock();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule